// File: doc/BRIEF.md
# Answer-Pin Telegram Sender

This block drives the answer telegram of a serially programmed sensor onto its output pin. Once the command receiver has processed a command, it pulses a start strobe together with a response kind and a 14-bit data word. The block then walks through the answer frame one bit period at a time and toggles the pin according to a transition-coded rule. A zero bit has no mid-bit change. A one bit has a mid-bit change placed at a fixed fraction of the period. Every bit closes with a toggle.

Write and program commands get a lone acknowledge bit. A read command gets the acknowledge bit, the 14 data bits most significant first, and a parity bit. The acknowledge bit always carries value zero, so it has a clean full-length period that tells the listener the output bit time. That bit time is a parameter in clock cycles and is longer than the bit time of the command line. A busy flag covers the whole response. Strobes that arrive while busy are dropped.

Top module: `resp_tx`

## Requirements
- R1: After reset, `pin_o` is high and `busy_o` is low.
- R2: While `busy_o` is low and no strobe is sampled, `pin_o` keeps its level, whatever `kind_i` and `data_i` do.
- R3: A clock edge that samples `start_i` high while `busy_o` is low toggles `pin_o` and raises `busy_o` on that same edge. This edge marks the start of the acknowledge bit.
- R4: The response kind is encoded as follows. `kind_i` = 0 gives an acknowledge-only frame of 1 bit, used for write and program commands. `kind_i` = 1 gives a read frame of 16 bits.
- R5: Every bit ends with a toggle exactly `BIT_CYC` clock edges after the edge that started it. The next bit starts on that same edge.
- R6: A one bit gets one extra toggle `MID_POS` = floor(`BIT_CYC`*`MID_PCT`/100) edges after its start. A zero bit has no extra toggle. The acknowledge bit is always zero.
- R7: A read frame is sent in this order: the acknowledge bit, then `data_i[13]` down to `data_i[0]`, then a parity bit. With the default `PARITY_ODD` = 0, the parity bit makes the total number of ones across the 14 data bits and the parity bit even.
- R8: `busy_o` falls on the edge that drives the final end-of-bit toggle. It stays high for exactly (frame bits × `BIT_CYC`) edges counted from the accepting edge.
- R9: A strobe sampled while `busy_o` is high has no effect on the frame in progress.
- R10: `kind_i` and `data_i` are captured on the accepting edge. Changes after that edge do not alter the frame.
- R11: A strobe sampled on the first edge after `busy_o` has fallen is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to send an answer |
| kind_i | input | 1 | 0: acknowledge only; 1: read answer |
| data_i | input | DATA_W | Register word for a read answer |
| pin_o | output | 1 | Transition-coded output line |
| busy_o | output | 1 | High while an answer is being sent |

## Verification
The assertions assume that `start_i` is a clean synchronous level, and that `BIT_CYC` and `MID_PCT` place the mid-bit change strictly inside the period. They make no assumption about how strobes are spaced, so a strobe during busy is legal input. The stimulus changes inputs only between clock edges. It uses a short bit period so that every edge of each frame can be compared against a waveform computed from the frame bits. It deliberately injects stray strobes and changes the data word in the middle of frames.

// File: rtl/resp_tx_pkg.sv
`timescale 1ns/1ps
package resp_tx_pkg;

   typedef enum logic {
      RTX_ACK_ONLY = 1'b0,
      RTX_READ     = 1'b1
   } rtx_kind_e;

   // Number of bits in a frame of the given kind
   function automatic int unsigned rtx_frame_bits(rtx_kind_e k, int unsigned dw);
      return (k == RTX_READ) ? dw + 2 : 1;
   endfunction

endpackage

// File: rtl/rtx_bit_timer.sv
`timescale 1ns/1ps
module rtx_bit_timer #(
   parameter int unsigned BIT_CYC = 150000,
   parameter int unsigned MID_POS = 97500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic mid_hit,
   output logic end_hit
);
   localparam int unsigned CW = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
   localparam logic [CW-1:0] LAST_CNT = CW'(BIT_CYC - 1);
   localparam logic [CW-1:0] MID_CNT  = CW'(MID_POS - 1);

   if (MID_POS < 1 || MID_POS >= BIT_CYC) begin : g_bad_mid
      $error("rtx_bit_timer: MID_POS must lie inside the bit period");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (run) begin
         if (cnt_q == LAST_CNT) cnt_q <= '0;
         else                   cnt_q <= cnt_q + 1'b1;
      end
   end

   assign end_hit = run && !restart && (cnt_q == LAST_CNT);
   assign mid_hit = run && !restart && (cnt_q == MID_CNT);

   // R5: the cycle counter never leaves the bit period
   a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_CNT);

   // R5: a bit end wraps the counter back to the start of the next bit
   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      end_hit |=> (cnt_q == '0));

endmodule

// File: rtl/rtx_frame_reg.sv
`timescale 1ns/1ps
module rtx_frame_reg
   import resp_tx_pkg::*;
#(
   parameter int unsigned DATA_W     = 14,
   parameter bit          PARITY_ODD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  rtx_kind_e         kind,
   input  logic [DATA_W-1:0] data,
   input  logic              advance,
   output logic              cur_bit,
   output logic              last_bit
);
   localparam int unsigned FW = DATA_W + 2;
   localparam int unsigned LW = $clog2(FW + 1);

   if (DATA_W < 1) begin : g_bad_dw
      $error("rtx_frame_reg: DATA_W must be at least 1");
   end

   logic par;
   if (PARITY_ODD) begin : g_par_odd
      assign par = ~^data;
   end else begin : g_par_even
      assign par = ^data;
   end

   logic [FW-1:0] sh_q;
   logic [LW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
      end else if (load) begin
         sh_q   <= {1'b0, data, par};
         left_q <= LW'(rtx_frame_bits(kind, DATA_W));
      end else if (advance && left_q != '0) begin
         sh_q   <= {sh_q[FW-2:0], 1'b0};
         left_q <= left_q - 1'b1;
      end
   end

   assign cur_bit  = sh_q[FW-1];
   assign last_bit = (left_q == LW'(1));

   // R4: an acknowledge-only load leaves a single bit to send
   a_r4_ack_len: assert property (@(posedge clk) disable iff (!rst_n)
      (load && kind == RTX_ACK_ONLY) |=> last_bit);

   // R6: the first bit of every frame is a zero acknowledge
   a_r6_ack_zero: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !cur_bit);

endmodule

// File: rtl/rtx_pin_drv.sv
`timescale 1ns/1ps
module rtx_pin_drv #(
   parameter bit IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flip,
   output logic pin
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pin <= IDLE_LVL;
      else if (flip) pin <= ~pin;
   end
endmodule

// File: rtl/resp_tx.sv
`timescale 1ns/1ps
module resp_tx
   import resp_tx_pkg::*;
#(
   parameter int unsigned DATA_W     = 14,
   parameter int unsigned BIT_CYC    = 150000,
   parameter int unsigned MID_PCT    = 65,
   parameter bit          PARITY_ODD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              kind_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              pin_o,
   output logic              busy_o
);
   localparam int unsigned MID_POS = (BIT_CYC * MID_PCT) / 100;

   if (MID_PCT < 50 || MID_PCT > 80) begin : g_bad_pct
      $error("resp_tx: MID_PCT must be within 50..80");
   end
   if (BIT_CYC < 8) begin : g_bad_cyc
      $error("resp_tx: BIT_CYC too small");
   end

   logic accept, mid_hit, end_hit, cur_bit, last_bit, flip, busy_q;

   assign accept = start_i && !busy_q;

   rtx_bit_timer #(.BIT_CYC(BIT_CYC), .MID_POS(MID_POS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .run     (busy_q),
      .mid_hit (mid_hit),
      .end_hit (end_hit)
   );

   rtx_frame_reg #(.DATA_W(DATA_W), .PARITY_ODD(PARITY_ODD)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .kind     (rtx_kind_e'(kind_i)),
      .data     (data_i),
      .advance  (end_hit),
      .cur_bit  (cur_bit),
      .last_bit (last_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    busy_q <= 1'b0;
      else if (accept)               busy_q <= 1'b1;
      else if (end_hit && last_bit)  busy_q <= 1'b0;
   end

   assign flip = accept || end_hit || (mid_hit && cur_bit);

   rtx_pin_drv #(.IDLE_LVL(1'b1)) u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .flip  (flip),
      .pin   (pin_o)
   );

   assign busy_o = busy_q;

   // R2: no activity on the line while idle
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(pin_o));

   // R3: an accepted strobe toggles the line and sets busy
   a_r3_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && pin_o != $past(pin_o)));

   // R5/R6: during a frame the line moves only at mid or end positions
   a_r6_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !mid_hit && !end_hit) |=> $stable(pin_o));

   // R8: busy drops together with the final toggle
   a_r8_fall_with_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (pin_o != $past(pin_o)));

   // R9: a stray strobe does not end or restart a frame early
   a_r9_stray_start: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !end_hit) |=> busy_o);

endmodule

// File: tb/sim_resp_tx.sv
`timescale 1ns/1ps
module sim_resp_tx;
   localparam int P   = 20;
   localparam int MID = (P * 65) / 100;
   localparam int DW  = 14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic kind_i = 1'b0;
   logic [DW-1:0] data_i = '0;
   logic pin_o, busy_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   resp_tx #(.DATA_W(DW), .BIT_CYC(P), .MID_PCT(65), .PARITY_ODD(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
      .data_i(data_i), .pin_o(pin_o), .busy_o(busy_o)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   function automatic logic exp_pin(input logic init, input logic [15:0] fb,
                                    input int nb, input int t);
      logic lvl = ~init;
      for (int b = 0; b < nb; b++) begin
         if (fb[15-b] && t >= b*P + MID) lvl = ~lvl;
         if (t >= (b+1)*P) lvl = ~lvl;
      end
      return lvl;
   endfunction

   // One answer frame, compared edge by edge. chg_t / inj_t: cycle at which
   // inputs are disturbed or a stray strobe is injected (-1: never).
   task automatic run_resp(input logic k, input logic [DW-1:0] d,
                           input int chg_t, input int inj_t, input string tag);
      logic init;
      logic [15:0] fb;
      int nb, pin_err, busy_err;
      pin_err = 0; busy_err = 0;
      nb = k ? 16 : 1;
      fb = {1'b0, d, ^d};
      init = pin_o;
      kind_i = k; data_i = d; start_i = 1'b1;
      for (int t = 0; t <= nb*P; t++) begin
         @(posedge clk); @(negedge clk);
         start_i = 1'b0;
         if (pin_o !== exp_pin(init, fb, nb, t)) pin_err++;
         if (busy_o !== (t < nb*P)) busy_err++;
         if (t == chg_t) begin kind_i = ~kind_i; data_i = ~data_i; end
         if (t == inj_t) begin start_i = 1'b1; kind_i = ~k; data_i = d ^ 14'h155; end
      end
      start_i = 1'b0;
      chk(pin_err == 0, {tag, " waveform R3 R5 R6 R7"}, pin_err, 0);
      chk(busy_err == 0, {tag, " busy span R8"}, busy_err, 0);
   endtask

   task automatic t_reset;
      chk(pin_o === 1'b1, "R1 reset pin", pin_o, 1);
      chk(busy_o === 1'b0, "R1 reset busy", busy_o, 0);
   endtask

   task automatic t_idle;
      logic lvl;
      int err;
      lvl = pin_o; err = 0;
      for (int i = 0; i < 25; i++) begin
         kind_i = i[0]; data_i = DW'(i * 37);
         @(posedge clk); @(negedge clk);
         if (pin_o !== lvl || busy_o !== 1'b0) err++;
      end
      chk(err == 0, "R2 idle hold", err, 0);
   endtask

   task automatic t_ack;      run_resp(1'b0, 14'h3FFF, -1, -1, "R4 ack-only"); endtask
   task automatic t_reads;
      run_resp(1'b1, 14'h0000, -1, -1, "R7 read zeros");
      run_resp(1'b1, 14'h3FFF, -1, -1, "R7 read ones");
      run_resp(1'b1, 14'h2AAA, -1, -1, "R7 read alt");
      run_resp(1'b1, 14'h1234, -1, -1, "R7 read mixed");
      run_resp(1'b1, 14'h2001, -1, -1, "R7 read ends");
   endtask
   task automatic t_stray;
      run_resp(1'b0, 14'h0001, -1, 7,   "R9 stray on ack");
      run_resp(1'b1, 14'h0F0F, -1, 150, "R9 stray on read");
   endtask
   task automatic t_capture;  run_resp(1'b1, 14'h1C3A, 2, -1, "R10 capture"); endtask
   task automatic t_b2b;
      run_resp(1'b0, 14'h0000, -1, -1, "R11 first");
      run_resp(1'b1, 14'h0ACE, -1, -1, "R11 back-to-back");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle();
      t_ack();
      t_reads();
      t_stray();
      t_capture();
      t_b2b();
      t_idle();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         chk(1'b0, "watchdog", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule